// File: doc/BRIEF.md
# DMA Basic-Transfer Address Generator

This block produces the source and destination addresses for each basic transfer inside a DMA minor loop. It also keeps the number of bytes still to move in the current minor loop. A channel engine holds a descriptor on the inputs: start addresses, signed per-access offsets, size codes, modulo widths, the minor-loop offset with its enables, and the two end-of-major adjustments. It then pulses `load` once. After that it strobes `beat_done` after each basic transfer, `minor_end` when a minor loop closes and `major_end` when the major loop closes.

Each basic transfer moves as many bytes as the wider of the two sides. The narrower side makes several accesses and steps its address once per access. Modulo wrapping keeps the upper address bits fixed and lets only the low N bits roll over. The minor-loop offset and the end-of-major adjustments are full-width additions applied after the wrapped step. A configuration check is captured at load time. It flags byte counts that do not divide evenly into the access sizes, and it flags size codes that have no meaning.

Top module: `dma_addr_gen`

## Requirements
- R1: Size codes decode as 000=1 byte, 001=2 bytes, 010=4 bytes, 100=16 bytes and 101=32 bytes. `beat_bytes` shows the larger of the source and destination sizes. A reserved code (011, 110, 111) counts as 1 byte for stepping.
- R2: On `beat_done`, each side adds its signed offset once for each of its accesses in the beat. A side makes `beat_bytes` divided by its own size accesses, so its step is the offset times that count.
- R3: Offset additions are two's-complement, modulo 2^AW. A negative offset moves the address down, and the result wraps through zero.
- R4: With modulo width N in 1..31, a beat leaves every address bit at position N or above unchanged and replaces the low N bits with the low N bits of the sum. N=0 disables wrapping.
- R5: `load` sets the byte count to `nbytes`. Each `beat_done` lowers it by `beat_bytes`, stopping at zero. `minor_end` or `major_end` restores it to `nbytes`. `minor_done` is high exactly when the count is zero.
- R6: On `minor_end`, the signed `mloff` is added to the source address when `map_en` and `src_ml_en` are both high. It is added to the destination address when `map_en` and `dst_ml_en` are both high. Otherwise `minor_end` does not change the addresses.
- R7: On `major_end`, `src_last` is added to the source address and `dst_last` is added to the destination address, with no modulo masking. When several strobes fall in one cycle, the beat step comes first and the minor and major corrections are added to its result.
- R8: `cfg_err` is updated only on `load`. It becomes 1 when a size code is reserved or when `nbytes` is not a multiple of both access sizes. Otherwise it becomes 0.
- R9: `load` takes precedence. In a load cycle the addresses take the start values and the count takes `nbytes`, whatever the other strobes are doing.
- R10: After a synchronous active-low reset, both addresses are 0, the count is 0 (so `minor_done` is 1) and `cfg_err` is 0.
- R11: In a cycle with no strobe, both addresses and the count hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load | input | 1 | Capture start addresses and byte count, and evaluate the configuration |
| beat_done | input | 1 | One basic transfer has completed |
| minor_end | input | 1 | Minor loop closes |
| major_end | input | 1 | Major loop closes |
| saddr | input | AW | Source start address |
| daddr | input | AW | Destination start address |
| soff | input | OFFW | Signed source offset per read access |
| doff | input | OFFW | Signed destination offset per write access |
| ssize | input | 3 | Source size code |
| dsize | input | 3 | Destination size code |
| smod | input | MODW | Source modulo width, 0 = off |
| dmod | input | MODW | Destination modulo width, 0 = off |
| nbytes | input | CW | Bytes per minor loop |
| map_en | input | 1 | Global enable for the minor-loop offset |
| src_ml_en | input | 1 | Apply the minor-loop offset to the source |
| dst_ml_en | input | 1 | Apply the minor-loop offset to the destination |
| mloff | input | MLW | Signed minor-loop offset |
| src_last | input | AW | Signed source adjustment at major end |
| dst_last | input | AW | Signed destination adjustment at major end |
| src_addr | output | AW | Current source address |
| dst_addr | output | AW | Current destination address |
| beat_bytes | output | 6 | Bytes per basic transfer |
| minor_done | output | 1 | Remaining byte count is zero |
| cfg_err | output | 1 | Descriptor captured at the last load is inconsistent |

## Verification
The hardest case to reach is a beat that crosses a modulo boundary while a minor-loop offset or an end-of-major adjustment lands on the same edge. The wrapped low bits and the unwrapped full-width correction must then combine in the right order. The stimulus aligns the start addresses so that the wrap falls on a chosen beat. It then asserts `beat_done` together with `minor_end` and `major_end` on that beat, using an unequal 2-byte to 4-byte size pair so that one side steps twice per beat. A behavioural model walks each access one at a time and is compared on every clock.

// File: rtl/dma_ag_pkg.sv
// Package dma_ag_pkg
// Shared size-code type and decode helpers for the address generator.
// Assumes 3-bit size codes; reserved codes decode as one byte.
package dma_ag_pkg;

    typedef logic [2:0] size_code_t;

    // Log2 of the access size in bytes for a size code.
    function automatic logic [2:0] size_log2(input size_code_t code);
        case (code)
            3'b000:  return 3'd0;
            3'b001:  return 3'd1;
            3'b010:  return 3'd2;
            3'b100:  return 3'd4;
            3'b101:  return 3'd5;
            default: return 3'd0;
        endcase
    endfunction

    // True for the size codes that carry a meaning.
    function automatic logic size_known(input size_code_t code);
        case (code)
            3'b000, 3'b001, 3'b010, 3'b100, 3'b101: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/dma_ag_size_dec.sv
// Module dma_ag_size_dec
// Decodes both size codes into the beat size and, for each side, the
// shift that turns its per-access offset into a per-beat step.
// Assumes the narrower side makes beat/size accesses in each beat.
module dma_ag_size_dec
    import dma_ag_pkg::*;
#(
    parameter int BBW = 6
) (
    input  size_code_t       ssize,
    input  size_code_t       dsize,
    output logic [2:0]       src_shift,
    output logic [2:0]       dst_shift,
    output logic [BBW-1:0]   beat_bytes,
    output logic             code_bad
);

    logic [2:0] slog;
    logic [2:0] dlog;
    logic [2:0] blog;

    // Pick the wider side and derive the access-count shift for each side.
    always_comb begin
        slog       = size_log2(ssize);
        dlog       = size_log2(dsize);
        blog       = (slog > dlog) ? slog : dlog;
        src_shift  = blog - slog;
        dst_shift  = blog - dlog;
        beat_bytes = BBW'(1) << blog;
        code_bad   = !size_known(ssize) || !size_known(dsize);
    end

endmodule

// File: rtl/dma_ag_addr_path.sv
// Module dma_ag_addr_path
// One address register with its step, modulo wrap, minor-loop offset
// and end-of-major adjustment. Used once for each side.
// Assumes AW is wider than OFFW and MLW; modulo widths below AW.
module dma_ag_addr_path #(
    parameter int AW   = 32,
    parameter int OFFW = 16,
    parameter int MLW  = 20,
    parameter int MODW = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [AW-1:0]        start_addr,
    input  logic                 beat,
    input  logic [OFFW-1:0]      step_off,
    input  logic [2:0]           step_shift,
    input  logic [MODW-1:0]      modw,
    input  logic                 minor_end,
    input  logic                 ml_apply,
    input  logic [MLW-1:0]       mloff,
    input  logic                 major_end,
    input  logic [AW-1:0]        last_adj,
    output logic [AW-1:0]        addr
);

    logic [AW-1:0] off_ext;
    logic [AW-1:0] advance;
    logic [AW-1:0] sum;
    logic [AW-1:0] mask;
    logic [AW-1:0] stepped;
    logic [AW-1:0] ml_ext;
    logic [AW-1:0] corrected;

    // Build the per-beat step, wrap the low bits, then add the loop corrections.
    always_comb begin
        off_ext   = {{(AW-OFFW){step_off[OFFW-1]}}, step_off};
        advance   = off_ext << step_shift;
        sum       = addr + advance;
        mask      = (modw == '0) ? '1 : ((AW'(1) << modw) - AW'(1));
        stepped   = beat ? ((addr & ~mask) | (sum & mask)) : addr;
        ml_ext    = {{(AW-MLW){mloff[MLW-1]}}, mloff};
        corrected = stepped
                  + ((minor_end && ml_apply) ? ml_ext : '0)
                  + (major_end ? last_adj : '0);
    end

    // Address register: reset, load of the start value, or corrected update.
    always_ff @(posedge clk) begin
        if (!rst_n)      addr <= '0;
        else if (load)   addr <= start_addr;
        else             addr <= corrected;
    end

    // R4: a beat with wrapping on and no correction keeps the upper bits.
    a_r4_upper_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (beat && !load && !minor_end && !major_end && modw != '0)
        |=> (((addr ^ $past(addr)) & ~$past(mask)) == '0));

    // R11: without any strobe the address holds.
    a_r11_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !beat && !minor_end && !major_end) |=> $stable(addr));

    // R9: load places the start address.
    a_r9_load_addr: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (addr == $past(start_addr)));

endmodule

// File: rtl/dma_ag_byte_count.sv
// Module dma_ag_byte_count
// Remaining-byte counter for the current minor loop.
// Assumes nbytes is stable while a minor loop runs; saturates at zero.
module dma_ag_byte_count #(
    parameter int CW  = 16,
    parameter int BBW = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             beat,
    input  logic             minor_end,
    input  logic             major_end,
    input  logic [CW-1:0]    nbytes,
    input  logic [BBW-1:0]   beat_bytes,
    output logic             minor_done
);

    logic [CW-1:0] count;
    logic [CW-1:0] beat_ext;
    logic          reload;

    // Widen the beat size and collect the reload conditions.
    always_comb begin
        beat_ext   = CW'(beat_bytes);
        reload     = load || minor_end || major_end;
        minor_done = (count == '0);
    end

    // Counter: reload at loop boundaries, saturating subtract per beat.
    always_ff @(posedge clk) begin
        if (!rst_n)          count <= '0;
        else if (reload)     count <= nbytes;
        else if (beat)       count <= (count > beat_ext) ? (count - beat_ext) : '0;
    end

    // R5: a loop boundary restores the full byte count.
    a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (minor_end || major_end) |=> (count == $past(nbytes)));

    // R5: a beat with enough bytes left removes exactly one beat.
    a_r5_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (beat && !reload && count >= beat_ext)
        |=> (count == $past(count) - $past(beat_ext)));

endmodule

// File: rtl/dma_addr_gen.sv
// Module dma_addr_gen
// Top of the basic-transfer address generator: size decode, two address
// paths, byte counter and the configuration check captured on load.
// Assumes descriptor inputs stay stable between load and the last strobe.
module dma_addr_gen #(
    parameter int AW   = 32,
    parameter int CW   = 16,
    parameter int OFFW = 16,
    parameter int MLW  = 20,
    parameter int MODW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              beat_done,
    input  logic              minor_end,
    input  logic              major_end,
    input  logic [AW-1:0]     saddr,
    input  logic [AW-1:0]     daddr,
    input  logic [OFFW-1:0]   soff,
    input  logic [OFFW-1:0]   doff,
    input  logic [2:0]        ssize,
    input  logic [2:0]        dsize,
    input  logic [MODW-1:0]   smod,
    input  logic [MODW-1:0]   dmod,
    input  logic [CW-1:0]     nbytes,
    input  logic              map_en,
    input  logic              src_ml_en,
    input  logic              dst_ml_en,
    input  logic [MLW-1:0]    mloff,
    input  logic [AW-1:0]     src_last,
    input  logic [AW-1:0]     dst_last,
    output logic [AW-1:0]     src_addr,
    output logic [AW-1:0]     dst_addr,
    output logic [5:0]        beat_bytes,
    output logic              minor_done,
    output logic              cfg_err
);

    localparam int BBW = 6;

    logic [2:0]    src_shift;
    logic [2:0]    dst_shift;
    logic          code_bad;
    logic          misfit;
    logic [CW-1:0] beat_mask;

    dma_ag_size_dec #(.BBW(BBW)) u_size (
        .ssize      (ssize),
        .dsize      (dsize),
        .src_shift  (src_shift),
        .dst_shift  (dst_shift),
        .beat_bytes (beat_bytes),
        .code_bad   (code_bad)
    );

    dma_ag_addr_path #(.AW(AW), .OFFW(OFFW), .MLW(MLW), .MODW(MODW)) u_src (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .start_addr (saddr),
        .beat       (beat_done),
        .step_off   (soff),
        .step_shift (src_shift),
        .modw       (smod),
        .minor_end  (minor_end),
        .ml_apply   (map_en && src_ml_en),
        .mloff      (mloff),
        .major_end  (major_end),
        .last_adj   (src_last),
        .addr       (src_addr)
    );

    dma_ag_addr_path #(.AW(AW), .OFFW(OFFW), .MLW(MLW), .MODW(MODW)) u_dst (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .start_addr (daddr),
        .beat       (beat_done),
        .step_off   (doff),
        .step_shift (dst_shift),
        .modw       (dmod),
        .minor_end  (minor_end),
        .ml_apply   (map_en && dst_ml_en),
        .mloff      (mloff),
        .major_end  (major_end),
        .last_adj   (dst_last),
        .addr       (dst_addr)
    );

    dma_ag_byte_count #(.CW(CW), .BBW(BBW)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .beat       (beat_done),
        .minor_end  (minor_end),
        .major_end  (major_end),
        .nbytes     (nbytes),
        .beat_bytes (beat_bytes),
        .minor_done (minor_done)
    );

    // A multiple of the wider size is also a multiple of the narrower one.
    always_comb begin
        beat_mask = CW'(beat_bytes) - CW'(1);
        misfit    = (nbytes & beat_mask) != '0;
    end

    // Configuration flag, refreshed only when a descriptor is loaded.
    always_ff @(posedge clk) begin
        if (!rst_n)    cfg_err <= 1'b0;
        else if (load) cfg_err <= code_bad || misfit;
    end

    // R8: between loads the configuration flag does not move.
    a_r8_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(cfg_err));

    // R9: a load leaves the full byte count, so the minor loop is not done
    // unless the loaded count is zero.
    a_r9_load_count: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (minor_done == ($past(nbytes) == '0)));

endmodule

// File: tb/dma_addr_gen_tb.sv
// Bench dma_addr_gen_tb: behavioural model stepped access by access,
// compared with the design after every clock.
module dma_addr_gen_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load = 0, beat_done = 0, minor_end = 0, major_end = 0;
    logic [31:0] saddr = 0, daddr = 0, src_last = 0, dst_last = 0;
    logic [15:0] soff = 0, doff = 0, nbytes = 0;
    logic [2:0]  ssize = 0, dsize = 0;
    logic [4:0]  smod = 0, dmod = 0;
    logic        map_en = 0, src_ml_en = 0, dst_ml_en = 0;
    logic [19:0] mloff = 0;
    logic [31:0] src_addr, dst_addr;
    logic [5:0]  beat_bytes;
    logic        minor_done, cfg_err;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [31:0] m_src = 0, m_dst = 0;
    int          m_cnt = 0;
    bit          m_err = 0;

    always #2.5 clk = ~clk;

    dma_addr_gen u_dut (
        .clk(clk), .rst_n(rst_n), .load(load), .beat_done(beat_done),
        .minor_end(minor_end), .major_end(major_end), .saddr(saddr),
        .daddr(daddr), .soff(soff), .doff(doff), .ssize(ssize),
        .dsize(dsize), .smod(smod), .dmod(dmod), .nbytes(nbytes),
        .map_en(map_en), .src_ml_en(src_ml_en), .dst_ml_en(dst_ml_en),
        .mloff(mloff), .src_last(src_last), .dst_last(dst_last),
        .src_addr(src_addr), .dst_addr(dst_addr), .beat_bytes(beat_bytes),
        .minor_done(minor_done), .cfg_err(cfg_err)
    );

    // Access size in bytes per code; 0 marks a reserved code.
    function automatic int sz(input logic [2:0] c);
        case (c)
            3'b000: return 1;
            3'b001: return 2;
            3'b010: return 4;
            3'b100: return 16;
            3'b101: return 32;
            default: return 0;
        endcase
    endfunction

    function automatic int eff(input logic [2:0] c);
        return (sz(c) == 0) ? 1 : sz(c);
    endfunction

    function automatic int beat_model();
        return (eff(ssize) > eff(dsize)) ? eff(ssize) : eff(dsize);
    endfunction

    // One access: add the offset, then keep the bits above the modulo width.
    function automatic logic [31:0] one_access(input logic [31:0] a,
                                               input logic [15:0] off,
                                               input logic [4:0] n);
        logic [31:0] s;
        logic [31:0] keep;
        s = a + {{16{off[15]}}, off};
        keep = (n == 0) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
        return (a & ~keep) | (s & keep);
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        chk(src_addr == m_src, tag, "src_addr", src_addr, m_src);
        chk(dst_addr == m_dst, tag, "dst_addr", dst_addr, m_dst);
        chk(minor_done == (m_cnt == 0), tag, "minor_done", minor_done, m_cnt == 0);
        chk(cfg_err == m_err, tag, "cfg_err", cfg_err, m_err);
        chk(int'(beat_bytes) == beat_model(), tag, "beat_bytes", beat_bytes, beat_model());
    endtask

    // Drive one cycle of strobes, advance the model, compare after the edge.
    task automatic step(input bit ld, input bit bt, input bit mn, input bit mj,
                        input string tag);
        int bb;
        load = ld; beat_done = bt; minor_end = mn; major_end = mj;
        @(posedge clk);
        bb = beat_model();
        if (ld) begin
            m_src = saddr; m_dst = daddr; m_cnt = int'(nbytes);
            m_err = (sz(ssize) == 0) || (sz(dsize) == 0)
                 || (int'(nbytes) % eff(ssize) != 0)
                 || (int'(nbytes) % eff(dsize) != 0);
        end else begin
            if (bt) begin
                for (int k = 0; k < bb / eff(ssize); k++) m_src = one_access(m_src, soff, smod);
                for (int k = 0; k < bb / eff(dsize); k++) m_dst = one_access(m_dst, doff, dmod);
            end
            if (mn && map_en && src_ml_en) m_src = m_src + {{12{mloff[19]}}, mloff};
            if (mn && map_en && dst_ml_en) m_dst = m_dst + {{12{mloff[19]}}, mloff};
            if (mj) begin
                m_src = m_src + src_last;
                m_dst = m_dst + dst_last;
            end
            if (mn || mj) m_cnt = int'(nbytes);
            else if (bt) m_cnt = (m_cnt > bb) ? m_cnt - bb : 0;
        end
        @(negedge clk);
        load = 0; beat_done = 0; minor_end = 0; major_end = 0;
        compare(tag);
    endtask

    initial begin
        #(5ns * 100000);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare("R10");                               // reset state

        // R2 R4: 2-byte reads, 4-byte writes, small wrap windows on both sides
        saddr = 32'h0000_1000; daddr = 32'h0000_2000;
        ssize = 3'b001; dsize = 3'b010; soff = 16'd2; doff = 16'd4;
        smod = 5'd3; dmod = 5'd4; nbytes = 16'd32;
        step(1, 0, 0, 0, "R9");
        for (int i = 0; i < 8; i++) step(0, 1, 0, 0, "R4");
        step(0, 0, 0, 0, "R11");
        step(0, 0, 0, 0, "R5");

        // R1 R2: 32-byte reads against 8-bit writes, no wrapping
        saddr = 32'h0001_0000; daddr = 32'h0002_0000;
        ssize = 3'b101; dsize = 3'b000; soff = 16'd32; doff = 16'd1;
        smod = 0; dmod = 0; nbytes = 16'd64;
        step(1, 0, 0, 0, "R1");
        step(0, 1, 0, 0, "R2");
        step(0, 1, 0, 0, "R5");

        // R3: negative offsets running through address zero
        saddr = 32'h0000_0004; daddr = 32'h0000_0002;
        ssize = 3'b010; dsize = 3'b001; soff = 16'hFFFC; doff = 16'hFFFE;
        nbytes = 16'd8;
        step(1, 0, 0, 0, "R9");
        for (int i = 0; i < 3; i++) step(0, 1, 0, 0, "R3");

        // R6: minor-loop offset gated by the global and per-side enables
        saddr = 32'h0000_4000; daddr = 32'h0000_8000;
        ssize = 3'b010; dsize = 3'b010; soff = 16'd4; doff = 16'd4;
        mloff = 20'hFFF00; nbytes = 16'd8;
        step(1, 0, 0, 0, "R9");
        step(0, 1, 0, 0, "R6");
        map_en = 0; src_ml_en = 1; dst_ml_en = 1;
        step(0, 1, 1, 0, "R6");
        map_en = 1; src_ml_en = 1; dst_ml_en = 0;
        step(0, 1, 1, 0, "R6");
        src_ml_en = 0; dst_ml_en = 1; mloff = 20'h00123;
        step(0, 0, 1, 0, "R6");

        // R7: wrap, minor offset and major adjustment on one edge
        saddr = 32'h0000_300C; daddr = 32'h0000_5018;
        ssize = 3'b001; dsize = 3'b010; soff = 16'd2; doff = 16'd4;
        smod = 5'd4; dmod = 5'd5; src_ml_en = 1; dst_ml_en = 1;
        mloff = 20'h00010; src_last = 32'hFFFF_FF00; dst_last = 32'h0000_0400;
        nbytes = 16'd16;
        step(1, 0, 0, 0, "R9");
        step(0, 1, 0, 0, "R4");
        step(0, 1, 1, 1, "R7");
        step(0, 0, 0, 1, "R7");

        // R8: count not a multiple, reserved code, then a clean load
        ssize = 3'b010; dsize = 3'b000; nbytes = 16'd6; smod = 0; dmod = 0;
        step(1, 0, 0, 0, "R8");
        step(0, 1, 0, 0, "R8");
        step(0, 1, 0, 0, "R5");                       // saturates at zero
        ssize = 3'b011; nbytes = 16'd8;
        step(1, 0, 0, 0, "R8");
        ssize = 3'b110; dsize = 3'b111;
        step(0, 1, 0, 0, "R1");
        ssize = 3'b000; dsize = 3'b001; nbytes = 16'd4;
        step(1, 0, 0, 0, "R8");

        // R9: load beats every other strobe in the same cycle
        saddr = 32'h0000_7700; daddr = 32'h0000_9900; nbytes = 16'd12;
        step(1, 1, 1, 1, "R9");
        step(0, 1, 0, 0, "R5");
        step(0, 0, 0, 0, "R11");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule